// File: doc/BRIEF.md
# Sprite Page Copy Engine

This block moves one page of bytes from the processor's address space into a fixed sprite-data port. It does this by taking over the bus from the processor. A trigger supplies the source page number. The engine then runs read and write cycles in turn. A read cycle fetches a byte from the next source address. The write cycle after it sends the held byte to the port at address 0x2004. While the engine owns the bus, the processor is held off. When the last byte has been written, the engine releases the processor and gives a one-cycle completion pulse.

A second, independent stall counter can be loaded with a cycle count. While it is nonzero, the processor is idle and nothing happens on the bus. This counter has the highest priority. Copy cycles come next, and normal instruction execution comes last. The processor reports the parity of its current cycle. A trigger that arrives on an odd cycle adds one alignment stall, so that the first read falls on an even cycle.

Top module: `sprite_dma`

## Requirements
- R1: After reset, cpu_stall_o, bus_en_o, bus_we_o and done_o are low, and bus_addr_o is 0.
- R2: Loading the stall counter with N holds cpu_stall_o high with bus_en_o low for exactly N cycles. The counter drops by one each cycle, and then cpu_stall_o falls.
- R3: A copy triggered while the stall counter is nonzero runs no bus cycle until the counter has reached zero.
- R4: A copy cycle with an even remaining count is a read (bus_en_o=1, bus_we_o=0) at the source pointer. The pointer then advances by one. The first read is at page*256.
- R5: A copy cycle with an odd remaining count is a write (bus_en_o=1, bus_we_o=1) to address 0x2004. Its data is the byte taken by the most recent read.
- R6: A trigger sets the remaining count to 512. Reads and writes alternate, starting with a read, and the 256 bytes go out in ascending source order.
- R7: A trigger sampled with odd_cycle_i=1 adds one stall cycle with no bus activity before the first read.
- R8: done_o is high for exactly one cycle, the cycle after the final write. In that cycle cpu_stall_o is low and bus_addr_o is 0, because the source pointer has been cleared. done_o is never high at any other time.
- R9: A trigger that arrives while a copy is still pending is ignored. It changes neither the page, the count nor the stall counter.
- R10: A stall-counter load of N on the same edge as an accepted odd-parity trigger gives N+1 idle stall cycles before the first read.
- R11: cpu_stall_o stays high from the accepted trigger until the final write. A stall-counter load during a copy pauses it, and the paused copy then resumes where it stopped with its held byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start request, one cycle |
| trig_page_i | input | 8 | Source page number |
| odd_cycle_i | input | 1 | Processor cycle parity, 1 = odd |
| steal_load_i | input | 1 | Load the stall counter |
| steal_cnt_i | input | 10 | Stall cycle count to load |
| rd_data_i | input | 8 | Bus read data |
| bus_en_o | output | 1 | Engine owns this bus cycle |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 8 | Write data |
| cpu_stall_o | output | 1 | Hold the processor |
| done_o | output | 1 | Copy finished pulse |

## Verification
Two things can happen on the same edge. The first is a stall-counter load arriving together with an odd-parity trigger. The bench drives both in one cycle and expects exactly N+1 idle cycles before the first read. The second is a stall load arriving in the middle of a copy, just after a read. The bench checks that the copy pauses for the loaded count, and that the following write still carries the byte from before the pause. A trigger sent during an active copy is also provoked. It is judged by the fact that every later address, datum and the completion cycle stay exactly as the original transfer predicts.

// File: rtl/sprdma_pkg.sv
package sprdma_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_HOLD  = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } bus_op_e;
endpackage

// File: rtl/sprdma_steal_ctr.sv
module sprdma_steal_ctr #(
  parameter int STEAL_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STEAL_W-1:0] load_val_i,
  input  logic               align_i,
  output logic               busy_o,
  output logic [STEAL_W-1:0] cnt_o
);
  localparam logic [STEAL_W-1:0] CNT_MAX = {STEAL_W{1'b1}};

  logic [STEAL_W-1:0] cnt_q, base, cnt_d;

  assign busy_o = (cnt_q != '0);

  always_comb begin
    if (load_i)      base = load_val_i;
    else if (busy_o) base = cnt_q - STEAL_W'(1);
    else             base = '0;
    // alignment stall rides on top of whatever remains, saturating
    if (align_i && base != CNT_MAX) cnt_d = base + STEAL_W'(1);
    else                            cnt_d = base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sprdma_seq.sv
module sprdma_seq
  import sprdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter int BYTES  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output bus_op_e           op_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [DATA_W-1:0] held_o,
  output logic              done_o
);
  localparam int OFF_W = $clog2(BYTES);
  localparam int CNT_W = $clog2(2 * BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(2 * BYTES);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] src_q;
  logic [DATA_W-1:0] held_q;
  logic              done_q;
  logic              step;

  assign busy_o = (cnt_q != '0);
  assign step   = busy_o && !hold_i;

  always_comb begin
    if (!busy_o)       op_o = OP_NONE;
    else if (hold_i)   op_o = OP_HOLD;
    else if (cnt_q[0]) op_o = OP_WRITE;
    else               op_o = OP_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      src_q  <= '0;
      held_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_o) begin
        cnt_q <= CNT_INIT;
        src_q <= ADDR_W'(page_i) << OFF_W;
      end else if (step) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (!cnt_q[0]) begin
          held_q <= rd_data_i;
          src_q  <= src_q + ADDR_W'(1);
        end
        if (cnt_q == CNT_W'(1)) begin
          src_q  <= '0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign src_o  = src_q;
  assign held_o = held_q;
  assign done_o = done_q;
endmodule

// File: rtl/sprdma_bus.sv
module sprdma_bus
  import sprdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
  input  bus_op_e           op_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [DATA_W-1:0] held_i,
  output logic              en_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_comb begin
    en_o    = 1'b0;
    we_o    = 1'b0;
    addr_o  = src_i;
    wdata_o = '0;
    unique case (op_i)
      OP_READ:  en_o = 1'b1;
      OP_WRITE: begin
        en_o    = 1'b1;
        we_o    = 1'b1;
        addr_o  = DEST_ADDR;
        wdata_o = held_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprdma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 8,
  parameter int BYTES     = 256,
  parameter int STEAL_W   = 10,
  parameter bit ALIGN_ODD = 1'b1,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic [PAGE_W-1:0]  trig_page_i,
  input  logic               odd_cycle_i,
  input  logic               steal_load_i,
  input  logic [STEAL_W-1:0] steal_cnt_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               bus_en_o,
  output logic               bus_we_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic [DATA_W-1:0]  bus_wdata_o,
  output logic               cpu_stall_o,
  output logic               done_o
);
  logic               steal_busy, dma_busy, trig_fire, align_fire;
  logic [STEAL_W-1:0] steal_cnt;
  bus_op_e            op;
  logic [ADDR_W-1:0]  src;
  logic [DATA_W-1:0]  held;

  assign trig_fire = trig_i && !dma_busy;

  generate
    if (ALIGN_ODD) begin : g_align
      assign align_fire = trig_fire && odd_cycle_i;
    end else begin : g_no_align
      assign align_fire = 1'b0;
    end
  endgenerate

  sprdma_steal_ctr #(.STEAL_W(STEAL_W)) u_steal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (steal_load_i),
    .load_val_i (steal_cnt_i),
    .align_i    (align_fire),
    .busy_o     (steal_busy),
    .cnt_o      (steal_cnt)
  );

  sprdma_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .BYTES(BYTES)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (trig_fire),
    .page_i    (trig_page_i),
    .hold_i    (steal_busy),
    .rd_data_i (rd_data_i),
    .busy_o    (dma_busy),
    .op_o      (op),
    .src_o     (src),
    .held_o    (held),
    .done_o    (done_o)
  );

  sprdma_bus #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEST_ADDR(DEST_ADDR)
  ) u_bus (
    .op_i    (op),
    .src_i   (src),
    .held_i  (held),
    .en_o    (bus_en_o),
    .we_o    (bus_we_o),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o)
  );

  // steal first, then copy, then instructions
  assign cpu_stall_o = steal_busy || dma_busy;
endmodule

// File: rtl/sprite_dma_chk.sv
module sprite_dma_chk #(
  parameter int ADDR_W  = 16,
  parameter int STEAL_W = 10,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               steal_load_i,
  input logic               bus_en_o,
  input logic               bus_we_o,
  input logic [ADDR_W-1:0]  bus_addr_o,
  input logic               cpu_stall_o,
  input logic               done_o,
  input logic               steal_busy,
  input logic [STEAL_W-1:0] steal_cnt,
  input logic               align_fire
);
  assert_steal_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steal_busy |-> !bus_en_o);

  assert_steal_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steal_busy && !steal_load_i && !align_fire) |=> steal_cnt == $past(steal_cnt) - STEAL_W'(1));

  assert_write_dest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_o && bus_we_o) |-> bus_addr_o == DEST_ADDR);

  assert_read_then_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_o && !bus_we_o) |=> (steal_busy || (bus_en_o && bus_we_o)));

  assert_align_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fire |=> (steal_busy && !bus_en_o));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cpu_stall_o && bus_addr_o == '0));

  assert_bus_stalls_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> cpu_stall_o);
endmodule

bind sprite_dma sprite_dma_chk #(
  .ADDR_W(ADDR_W), .STEAL_W(STEAL_W), .DEST_ADDR(DEST_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .steal_load_i (steal_load_i),
  .bus_en_o     (bus_en_o),
  .bus_we_o     (bus_we_o),
  .bus_addr_o   (bus_addr_o),
  .cpu_stall_o  (cpu_stall_o),
  .done_o       (done_o),
  .steal_busy   (steal_busy),
  .steal_cnt    (steal_cnt),
  .align_fire   (align_fire)
);

// File: tb/sprite_dma_tb.sv
`timescale 1ns/100ps
module sprite_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [7:0]  page = '0;
  logic        odd = 1'b0;
  logic        sload = 1'b0;
  logic [9:0]  sval = '0;
  logic [7:0]  rdata;
  logic        en, we, stall, done;
  logic [15:0] addr;
  logic [7:0]  wdata;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  assign rdata = mem_fn(addr);

  sprite_dma u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .trig_page_i(page),
    .odd_cycle_i(odd), .steal_load_i(sload), .steal_cnt_i(sval),
    .rd_data_i(rdata), .bus_en_o(en), .bus_we_o(we), .bus_addr_o(addr),
    .bus_wdata_o(wdata), .cpu_stall_o(stall), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(!stall && !en && !we && !done && addr == 16'h0, "R1", "reset outputs",
        {stall, en, we, done, addr}, 0);
  endtask

  task automatic t_steal_only(input int n);
    int bad = 0;
    @(negedge clk); sload = 1'b1; sval = 10'(n);
    @(negedge clk); sload = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (!(stall && !en)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R2", "steal window", bad, 0);
    chk(!stall && !en, "R2", "release after steal", {stall, en}, 0);
  endtask

  // drives a trigger at the next edge and follows the whole transfer
  task automatic t_dma(input logic [7:0] pg, input bit odd_t, input int sl, input int idle0,
                       input string idle_req, input int inj_at, input int pause_at,
                       input int pause_n);
    int idle_left = idle0;
    int j = 0, guard = 0;
    int idle_bad = 0, rd_bad = 0, wr_bad = 0, ord_bad = 0, early_done = 0, pause_bad = 0;
    int rd_a = 0, rd_e = 0, wr_a = 0, wr_e = 0;
    bit paused = 0, in_pause = 0;
    logic [15:0] base = {pg, 8'h00};
    logic [15:0] ea;
    @(negedge clk);
    trig = 1'b1; page = pg; odd = odd_t;
    if (sl >= 0) begin sload = 1'b1; sval = 10'(sl); end
    @(negedge clk);
    while (j < 512 && guard < 4000) begin
      trig = 1'b0; odd = 1'b0; sload = 1'b0;
      guard++;
      if (done) early_done++;
      if (idle_left > 0) begin
        if (!(stall && !en)) begin
          if (in_pause) pause_bad++; else idle_bad++;
        end
        idle_left--;
      end else begin
        in_pause = 0;
        ea = base + 16'(j / 2);
        if (!stall || !en) ord_bad++;
        if (j % 2 == 0) begin
          if (we || addr != ea) begin
            if (rd_bad == 0) begin rd_a = int'(addr); rd_e = int'(ea); end
            rd_bad++;
          end
        end else begin
          if (!we || addr != 16'h2004 || wdata != mem_fn(ea)) begin
            if (wr_bad == 0) begin wr_a = int'({addr, wdata}); wr_e = int'({16'h2004, mem_fn(ea)}); end
            wr_bad++;
          end
        end
        j++;
      end
      if (j == inj_at && inj_at > 0) begin
        trig = 1'b1; page = pg ^ 8'h3C; odd = 1'b1; inj_at = -1;
      end
      if (j == pause_at && !paused) begin
        sload = 1'b1; sval = 10'(pause_n); idle_left = pause_n; paused = 1; in_pause = 1;
      end
      @(negedge clk);
    end
    trig = 1'b0; odd = 1'b0; sload = 1'b0;
    chk(idle_bad == 0, idle_req, "idle stall cycles before first read", idle_bad, 0);
    chk(rd_bad == 0, "R4", "read address sequence", rd_a, rd_e);
    chk(wr_bad == 0, "R5", "write to port with held byte", wr_a, wr_e);
    chk(ord_bad == 0 && j == 512, "R6", "512 alternating bus cycles", j, 512);
    chk(ord_bad == 0, "R11", "stall during transfer", ord_bad, 0);
    chk(early_done == 0, "R8", "no early completion pulse", early_done, 0);
    if (pause_at > 0) chk(pause_bad == 0, "R11", "mid-copy pause quiet", pause_bad, 0);
    chk(done && !stall && !en && addr == 16'h0, "R8", "completion cycle",
        {done, stall, en, addr}, {1'b1, 1'b0, 1'b0, 16'h0});
    @(negedge clk);
    chk(!done && !stall, "R8", "pulse one cycle", {done, stall}, 0);
  endtask

  initial begin
    #(200000 * 5);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_steal_only(7);
    // R4 R5 R6 R8 plain even-parity copy
    t_dma(8'h03, 1'b0, -1, 0, "R6", 0, 0, 0);
    // R7 odd parity adds one stall
    t_dma(8'hA7, 1'b1, -1, 1, "R7", 0, 0, 0);
    // R3 trigger during an active steal window: 5 loaded, trigger two edges later
    @(negedge clk); sload = 1'b1; sval = 10'd5;
    @(negedge clk); sload = 1'b0;
    t_dma(8'h40, 1'b0, -1, 3, "R3", 0, 0, 0);
    // R10 steal load and odd trigger on the same edge
    t_dma(8'h12, 1'b1, 4, 5, "R10", 0, 0, 0);
    // R9 trigger mid-copy ignored, top page
    t_dma(8'hFF, 1'b0, -1, 0, "R9", 101, 0, 0);
    chk(!stall, "R9", "ignored trigger left no pending work", stall, 0);
    // R11 steal load right after a read pauses the copy
    t_dma(8'h55, 1'b0, -1, 0, "R11", 0, 201, 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule